// File: doc/BRIEF.md
# Cell-Level Receive Master with Errored-Cell Discard

This block is the receive side of a single-PHY, cell-level master on an 8-bit Utopia bus. It watches the slave's cell-available line and pulls the active-low receive enable low when a whole cell is ready. It then captures the bytes that follow a start-of-cell marker. Each cell is checked in two ways: per-byte parity, which can be switched on or off, and cell length against a configured cell size. The slave may keep sending cells back to back while enable stays low. When the slave reports no further cell, the enable is released two cycles before the expected last byte.

Downstream logic receives every captured byte through a write port, with a marker on the first byte of each cell. A cell ends with a strobe. A commit strobe keeps the bytes written for the cell. An abort strobe tells downstream to throw the whole cell away. Each abort comes with a one-cycle error pulse and a two-bit cause code, so management logic can count discards by cause. The cell size is set from a configuration input in the range 8 to 255 bytes. The parity sense is odd by default and can be set by a parameter.

Top module: `utp_rx_master`

## Requirements
- R1: While reset is applied, and until the first cell activity after it, `rx_enb_n` is 1 and `wr_valid`, `out_commit`, `out_abort` and `err_pulse` are 0.
- R2: When the block is idle (enable released, no cell open) and `rx_clav` is 1, `rx_enb_n` goes to 0 in the next cycle.
- R3: Inside a cell of length L, the byte at index L-4 (index 0 is the start-of-cell byte) is where `rx_clav` is sampled. If it is 0 there, `rx_enb_n` is 1 from the next cycle, which is two cycles before the last byte. If it is 1, `rx_enb_n` stays 0 across the cell boundary.
- R4: A byte with `rx_soc`=1 opens a cell only if `rx_enb_n` was 0 in the previous cycle. Bytes with `rx_soc`=0 outside an open cell are dropped, and nothing appears on the write port for them.
- R5: Each byte taken into a cell appears on `wr_data` with `wr_valid`=1 one cycle after it was on `rx_data`. `wr_first` is 1 for the start-of-cell byte. A cell's closing strobe comes one cycle after the byte that closed it.
- R6: A cell of exactly `cfg_cell_len` bytes with no error raises `out_commit` in the same cycle as the write of its last byte. The committed bytes equal the bytes received.
- R7: A byte is good when the 9 bits `{rx_data, rx_prty}` hold an odd number of ones. With `cfg_par_en`=1, one bad byte anywhere in a full-length cell makes the cell close with `out_abort`=1, `err_pulse`=1 and `err_stat` bit 0 (parity cause) set.
- R8: With `cfg_par_en`=0, parity is ignored: `err_stat` bit 0 is never set, and cells with bad parity commit.
- R9: A start-of-cell that arrives while a cell is open with fewer than `cfg_cell_len` bytes aborts the open cell. `err_pulse`=1 and `err_stat` bit 1 (length cause) is set, and bit 0 is also set if that cell already had a parity error. The strobe comes in the cycle where the new start byte is written with `wr_first`=1, and the new cell opens.
- R10: `err_pulse` is 1 exactly when `out_abort` is 1. `out_commit` and `out_abort` are never both 1. `err_stat` is 0 whenever `err_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_par_en | input | 1 | 1 enables the parity check |
| cfg_cell_len | input | LEN_W | Cell size in bytes (8 or more), changed only while idle |
| rx_clav | input | 1 | Slave has a complete cell ready |
| rx_enb_n | output | 1 | Active-low receive enable to the slave |
| rx_data | input | DATA_W | Byte from the slave |
| rx_prty | input | 1 | Parity bit for rx_data |
| rx_soc | input | 1 | Marks the first byte of a cell |
| wr_valid | output | 1 | Byte write strobe to downstream |
| wr_first | output | 1 | Written byte starts a cell |
| wr_data | output | DATA_W | Written byte |
| out_commit | output | 1 | Keep the open cell |
| out_abort | output | 1 | Discard the open cell |
| err_pulse | output | 1 | One-cycle discard indication |
| err_stat | output | 2 | Discard cause: bit 0 parity, bit 1 length |

## Verification
Every result on the write side is due exactly one cycle after the input byte that caused it. This holds for the write strobe, the commit and abort strobes, and the cause code. The bench records the cycle number of the byte that closes each cell (the last byte, or the next start-of-cell for a short cell) and expects the strobe at that cycle plus one. The enable reacts with one register of delay, so the bench checks it one cycle after the deciding input. It does this by reading `rx_enb_n` at the falling edge of the cycle in which the slave model drives the byte at index L-3. It also checks that `rx_enb_n` goes low exactly one cycle after cell-available is raised from idle.

// File: rtl/utp_rx_pkg.sv
package utp_rx_pkg;
  localparam int unsigned ERR_PAR_BIT = 0;
  localparam int unsigned ERR_LEN_BIT = 1;

  typedef enum logic [1:0] {
    CLOSE_NONE = 2'd0,
    CLOSE_GOOD = 2'd1,
    CLOSE_BAD  = 2'd2
  } close_e;

  typedef struct packed {
    close_e     kind;
    logic [1:0] cause;
  } close_t;
endpackage

// File: rtl/utp_rx_enable.sv
module utp_rx_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic clav,
  input  logic in_cell,
  input  logic near_end,
  output logic enb_n,
  output logic en_seen
);
  logic on_q, on_d;
  logic seen_q;

  always_comb begin
    on_d = on_q;
    if (!on_q) begin
      if (clav && !in_cell) on_d = 1'b1;
    end else if (near_end && !clav) begin
      on_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      on_q   <= on_d;
      seen_q <= on_q;
    end
  end

  assign enb_n   = ~on_q;
  assign en_seen = seen_q;
endmodule

// File: rtl/utp_rx_framer.sv
module utp_rx_framer
  import utp_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 8,
  parameter bit          ODD    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_en,
  input  logic [LEN_W-1:0]  cell_len,
  input  logic              en_seen,
  input  logic              soc,
  input  logic [DATA_W-1:0] data,
  input  logic              prty,
  output logic              in_cell,
  output logic              near_end,
  output logic              take,
  output logic              first,
  output close_t            close
);
  logic             in_q, in_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             pbad_q, pbad_d;
  logic             byte_bad, pbad_now;
  logic             start, cont, trunc, last;

  generate
    if (ODD) begin : g_odd
      assign byte_bad = ~(^{data, prty});
    end else begin : g_even
      assign byte_bad = ^{data, prty};
    end
  endgenerate

  assign pbad_now = par_en & byte_bad;
  assign start    = soc & en_seen;
  assign cont     = in_q & ~soc;
  assign trunc    = in_q & soc;
  assign last     = cont && (cnt_q == cell_len - LEN_W'(1));
  assign near_end = cont && (cnt_q == cell_len - LEN_W'(4));
  assign take     = start | cont;
  assign first    = start;
  assign in_cell  = in_q;

  always_comb begin
    close = '{kind: CLOSE_NONE, cause: 2'b00};
    if (trunc) begin
      close.kind               = CLOSE_BAD;
      close.cause[ERR_LEN_BIT] = 1'b1;
      close.cause[ERR_PAR_BIT] = pbad_q;
    end else if (last) begin
      if (pbad_q || pbad_now) begin
        close.kind               = CLOSE_BAD;
        close.cause[ERR_PAR_BIT] = 1'b1;
      end else begin
        close.kind = CLOSE_GOOD;
      end
    end
  end

  always_comb begin
    in_d   = in_q;
    cnt_d  = cnt_q;
    pbad_d = pbad_q;
    if (start) begin
      in_d   = 1'b1;
      cnt_d  = LEN_W'(1);
      pbad_d = pbad_now;
    end else if (trunc) begin
      in_d   = 1'b0;
      cnt_d  = '0;
      pbad_d = 1'b0;
    end else if (last) begin
      in_d   = 1'b0;
      cnt_d  = '0;
      pbad_d = 1'b0;
    end else if (cont) begin
      cnt_d  = cnt_q + LEN_W'(1);
      pbad_d = pbad_q | pbad_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      cnt_q  <= '0;
      pbad_q <= 1'b0;
    end else begin
      in_q   <= in_d;
      cnt_q  <= cnt_d;
      pbad_q <= pbad_d;
    end
  end
endmodule

// File: rtl/utp_rx_outreg.sv
module utp_rx_outreg
  import utp_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [DATA_W-1:0] data,
  input  close_t            close,
  output logic              wr_valid,
  output logic              wr_first,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_commit,
  output logic              out_abort,
  output logic [1:0]        cause
);
  logic              v_q, f_q, c_q, a_q;
  logic [DATA_W-1:0] d_q;
  logic [1:0]        cause_q, cause_d;

  assign cause_d = (close.kind == CLOSE_BAD) ? close.cause : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      f_q     <= 1'b0;
      c_q     <= 1'b0;
      a_q     <= 1'b0;
      cause_q <= 2'b00;
    end else begin
      v_q     <= take;
      f_q     <= first;
      c_q     <= (close.kind == CLOSE_GOOD);
      a_q     <= (close.kind == CLOSE_BAD);
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
    end else if (take) begin
      d_q <= data;
    end
  end

  assign wr_valid   = v_q;
  assign wr_first   = f_q;
  assign wr_data    = d_q;
  assign out_commit = c_q;
  assign out_abort  = a_q;
  assign cause      = cause_q;
endmodule

// File: rtl/utp_rx_master.sv
module utp_rx_master
  import utp_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 8,
  parameter bit          ODD    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_par_en,
  input  logic [LEN_W-1:0]  cfg_cell_len,
  input  logic              rx_clav,
  output logic              rx_enb_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_prty,
  input  logic              rx_soc,
  output logic              wr_valid,
  output logic              wr_first,
  output logic [DATA_W-1:0] wr_data,
  output logic              out_commit,
  output logic              out_abort,
  output logic              err_pulse,
  output logic [1:0]        err_stat
);
  logic [1:0] rs_q;
  logic       rst_i_n;
  logic       in_cell, near_end, en_seen, take, first;
  close_t     close;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  utp_rx_enable u_enable (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clav     (rx_clav),
    .in_cell  (in_cell),
    .near_end (near_end),
    .enb_n    (rx_enb_n),
    .en_seen  (en_seen)
  );

  utp_rx_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .ODD(ODD)) u_framer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .par_en   (cfg_par_en),
    .cell_len (cfg_cell_len),
    .en_seen  (en_seen),
    .soc      (rx_soc),
    .data     (rx_data),
    .prty     (rx_prty),
    .in_cell  (in_cell),
    .near_end (near_end),
    .take     (take),
    .first    (first),
    .close    (close)
  );

  utp_rx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .take       (take),
    .first      (first),
    .data       (rx_data),
    .close      (close),
    .wr_valid   (wr_valid),
    .wr_first   (wr_first),
    .wr_data    (wr_data),
    .out_commit (out_commit),
    .out_abort  (out_abort),
    .cause      (err_stat)
  );

  assign err_pulse = out_abort;
endmodule

// File: rtl/utp_rx_master_chk.sv
module utp_rx_master_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_par_en,
  input logic [LEN_W-1:0] cfg_cell_len,
  input logic             rx_clav,
  input logic             rx_enb_n,
  input logic             wr_valid,
  input logic             wr_first,
  input logic             out_commit,
  input logic             out_abort,
  input logic             err_pulse,
  input logic [1:0]       err_stat
);
  logic [LEN_W:0] wcnt_q, wcnt_d;
  logic           pen_q, pen_d;
  logic           closing;

  assign closing = out_commit | out_abort;

  always_comb begin
    wcnt_d = wcnt_q;
    if (closing)       wcnt_d = (wr_valid && wr_first) ? (LEN_W+1)'(1) : '0;
    else if (wr_valid) wcnt_d = wr_first ? (LEN_W+1)'(1) : wcnt_q + (LEN_W+1)'(1);
    pen_d = closing ? cfg_par_en : (pen_q | cfg_par_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      pen_q  <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      pen_q  <= pen_d;
    end
  end

  // R2
  enb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_enb_n) |-> $past(rx_clav));

  // R3
  enb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_enb_n) |-> $past(!rx_clav));

  // R6
  commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_commit |-> (wr_valid && !wr_first && (wcnt_q + (LEN_W+1)'(1) == {1'b0, cfg_cell_len})));

  // R9
  short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_abort && err_stat[1]) |-> (wcnt_q < {1'b0, cfg_cell_len}));

  // R8
  par_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && err_stat[0]) |-> pen_q);

  // R10
  close_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_commit, out_abort}));

  // R10
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> (err_stat == 2'b00));
endmodule

bind utp_rx_master utp_rx_master_chk #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_par_en   (cfg_par_en),
  .cfg_cell_len (cfg_cell_len),
  .rx_clav      (rx_clav),
  .rx_enb_n     (rx_enb_n),
  .wr_valid     (wr_valid),
  .wr_first     (wr_first),
  .out_commit   (out_commit),
  .out_abort    (out_abort),
  .err_pulse    (err_pulse),
  .err_stat     (err_stat)
);

// File: tb/utp_rx_master_test.sv
`timescale 1ns/1ps
module utp_rx_master_test;
  localparam int DW = 8;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_par_en = 1'b1;
  logic [LW-1:0] cfg_cell_len = LW'(16);
  logic          rx_clav = 1'b0;
  logic          rx_enb_n;
  logic [DW-1:0] rx_data = '0;
  logic          rx_prty = 1'b1;
  logic          rx_soc = 1'b0;
  logic          wr_valid, wr_first, out_commit, out_abort, err_pulse;
  logic [DW-1:0] wr_data;
  logic [1:0]    err_stat;

  utp_rx_master #(.DATA_W(DW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .cfg_cell_len(cfg_cell_len),
    .rx_clav(rx_clav), .rx_enb_n(rx_enb_n), .rx_data(rx_data), .rx_prty(rx_prty),
    .rx_soc(rx_soc), .wr_valid(wr_valid), .wr_first(wr_first), .wr_data(wr_data),
    .out_commit(out_commit), .out_abort(out_abort), .err_pulse(err_pulse), .err_stat(err_stat)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit       ok;
    bit [1:0] code;
    int       cyc;
    int       nbytes;
  } exp_t;
  exp_t exp_q[$];
  byte unsigned exp_b[$];
  byte unsigned cur[$];

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit good_par(input byte unsigned d);
    return ~(^d);
  endfunction

  function automatic string close_req(input bit ok, input bit [1:0] code);
    if (ok) return "R6";
    if (code[1]) return "R9";
    return "R7";
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (mon_on) begin
      check(!(err_pulse && !out_abort) && !(out_abort && !err_pulse), "R10",
            "err_pulse vs out_abort", err_pulse, out_abort);
      if (!err_pulse) check(err_stat == 2'b00, "R10", "err_stat idle", err_stat, 0);
      if (wr_valid && !wr_first) cur.push_back(wr_data);
      if (out_commit || out_abort) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected cell close", 1, 0);
        end else begin
          exp_t e;
          string rq;
          e  = exp_q.pop_front();
          rq = close_req(e.ok, e.code);
          check(out_commit == e.ok, rq, "commit vs abort", out_commit, e.ok);
          check(cyc == e.cyc + 1, "R5", "close strobe cycle", cyc, e.cyc + 1);
          if (!e.ok) begin
            check(err_stat == e.code, rq, "err_stat code", err_stat, e.code);
          end else begin
            check(cur.size() == e.nbytes, "R6", "committed byte count", cur.size(), e.nbytes);
            for (int k = 0; k < e.nbytes; k++) begin
              byte unsigned x;
              x = exp_b.pop_front();
              if (k < cur.size())
                check(cur[k] == x, "R5", "committed byte value", cur[k], x);
            end
          end
        end
        cur.delete();
      end
      if (wr_valid && wr_first) begin
        cur.delete();
        cur.push_back(wr_data);
      end
    end
  end

  // slave model: one burst of cells, back to back while enable stays low
  task automatic run_burst(input int ncells, input int short_mask,
                           input int force_mask, input int bad_pct);
    int  len;
    int  w;
    bit  prev_short;
    bit  prev_perr;
    len = int'(cfg_cell_len);
    prev_short = 1'b0;
    prev_perr  = 1'b0;
    rx_clav = 1'b1;
    w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (rx_enb_n !== 1'b0 && w < 50);
    check(w == 1, "R2", "cycles from clav to enable", w, 1);
    for (int g = 0; g < int'($urandom % 3); g++) begin
      @(negedge clk);
      rx_soc  = 1'b0;
      rx_data = DW'($urandom);
      rx_prty = 1'($urandom);
    end
    for (int i = 0; i < ncells; i++) begin
      bit sh;
      int n;
      bit perr;
      byte unsigned bq[$];
      sh   = ((short_mask >> i) & 1) != 0 && (i < ncells - 1);
      n    = sh ? 1 + int'($urandom % (len - 1)) : len;
      perr = 1'b0;
      for (int j = 0; j < n; j++) begin
        byte unsigned d;
        bit bad;
        @(negedge clk);
        if (j == 0 && prev_short) begin
          exp_q.push_back('{ok: 1'b0, code: {1'b1, prev_perr}, cyc: cyc, nbytes: 0});
        end
        d   = byte'($urandom);
        bad = (j == 0 && ((force_mask >> i) & 1) != 0) || (int'($urandom % 100) < bad_pct);
        rx_data = d;
        rx_prty = bad ? ~good_par(d) : good_par(d);
        rx_soc  = (j == 0);
        if (j == 0) rx_clav = (i < ncells - 1);
        if (bad && cfg_par_en) perr = 1'b1;
        bq.push_back(d);
        if (!sh && j == len - 4)
          check(rx_enb_n == 1'b0, "R3", "enable held at index L-4", rx_enb_n, 0);
        if (!sh && j == len - 3)
          check(rx_enb_n == (i == ncells - 1), "R3", "enable at index L-3",
                rx_enb_n, (i == ncells - 1));
        if (!sh && j == n - 1) begin
          exp_q.push_back('{ok: !perr, code: perr ? 2'b01 : 2'b00, cyc: cyc,
                            nbytes: perr ? 0 : n});
          if (!perr) foreach (bq[k]) exp_b.push_back(bq[k]);
        end
      end
      prev_short = sh;
      prev_perr  = perr;
    end
    @(negedge clk);
    rx_soc  = 1'b0;
    rx_data = DW'($urandom);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R6", "cells left unclosed", exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(rx_enb_n == 1'b1, "R1", "enable during reset", rx_enb_n, 1);
    check(!wr_valid && !out_commit && !out_abort && !err_pulse, "R1", "outputs during reset",
          {wr_valid, out_commit, out_abort, err_pulse}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(rx_enb_n == 1'b1, "R1", "enable after reset", rx_enb_n, 1);
    mon_on = 1'b1;

    // R4: start-of-cell while enable released is dropped
    rx_soc = 1'b1; rx_data = 8'h5a; rx_prty = good_par(8'h5a);
    @(negedge clk);
    rx_soc = 1'b0;
    check(wr_valid == 1'b0, "R4", "soc without enable written", wr_valid, 0);
    @(negedge clk);
    check(wr_valid == 1'b0, "R4", "stray byte written", wr_valid, 0);

    run_burst(3, 0, 0, 0);           // R6 back to back, R3 hold
    run_burst(1, 0, 0, 0);           // R3 single cell release
    run_burst(4, 0, 'b0101, 0);      // R7 parity discard
    run_burst(4, 'b0010, 0, 0);      // R9 short cell
    run_burst(3, 'b0001, 'b0001, 0); // R9 with parity: code 3
    cfg_par_en = 1'b0;
    run_burst(3, 0, 'b0111, 30);     // R8 parity ignored
    cfg_par_en = 1'b1;
    cfg_cell_len = LW'(8);
    run_burst(3, 0, 0, 0);           // minimum cell size
    for (int b = 0; b < 24; b++) begin
      cfg_cell_len = LW'(8 + $urandom % 33);
      cfg_par_en   = ($urandom % 4) != 0;
      run_burst(1 + int'($urandom % 5), int'($urandom % 16), int'($urandom % 16), 3);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule